// File: doc/BRIEF.md
# Hashed Page Table Walker

This block resolves an address-translation miss in hardware. It takes a virtual page number and a process identifier and looks the pair up in a hashed translation table held in memory. It hashes the pair to pick a slot, adds the slot offset to a programmable table base, and reads the slot's entries one at a time through a single-outstanding memory read port. It compares each entry with the wanted page number as it arrives.

If the first slot has no match, the walker searches a second slot picked by an alternate hash. It stops at the first matching entry and returns the physical page number. If neither slot holds the translation, it reports an unresolved miss so that software can fall back to its complete table. The slot count is a power of two set by a parameter. This lets the table be sized at a small multiple of the physical page count.

Top module: `hpt_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, and `done` and `mem_req` are 0.
- R2: The primary slot index is the low SLOT_BITS bits of the page number XOR the zero-extended process identifier. Entry k of slot s is read at byte address base + s*ENTRIES*8 + k*8. The entries are read in increasing k, starting at k = 0.
- R3: An entry is a 64-bit word. Bit 63 is valid, and bit 62 is the slot kind (0 = primary, 1 = secondary). Bits [32+VPN_W-1:32] hold the page tag and bits [PPN_W-1:0] hold the physical page. An entry matches only when all three hold: valid is 1, the tag equals the page number, and the kind bit equals the kind of the slot being searched.
- R4: The search stops at the first matching entry. `done` is raised with `hit` = 1 and `ppn` taken from that entry. The number of reads is one more than the number of entries examined before it.
- R5: After all ENTRIES entries of the primary slot fail, the walker searches the secondary slot, whose index is the bitwise complement of the primary index. It reads the secondary entries from k = 0 in the same way.
- R6: When no entry of either slot matches, `done` is raised with `hit` = 0 and `ppn` = 0, after exactly 2*ENTRIES reads.
- R7: At most one read is outstanding. `mem_req` is a one-cycle pulse, and it is not raised again until `mem_rvalid` has returned the data for the previous read.
- R8: A request is taken only while `req_ready` is 1, and `req_ready` is 1 only while the walker is idle. A `req_valid` held during a walk starts no reads and produces no extra result.
- R9: `done` is high for exactly one cycle, and `req_ready` is 1 in the following cycle.
- R10: The table base, page number and process identifier are captured when a request is taken. A change on `tbl_base` during a walk does not move the remaining reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_base | input | ADDR_W | Byte address of slot 0 of the table |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vpn | input | VPN_W | Virtual page number to resolve |
| req_pid | input | PID_W | Process identifier |
| mem_req | output | 1 | Read request pulse |
| mem_addr | output | ADDR_W | Byte address of the entry to read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Entry read from memory |
| done | output | 1 | One-cycle result strobe |
| hit | output | 1 | Translation found (valid with done) |
| ppn | output | PPN_W | Physical page number (valid with done, 0 on miss) |

## Verification
The bench builds the walker with SLOT_BITS = 3, PID_W = 3, VPN_W = PPN_W = 12 and ENTRIES = 8. With these values the whole table is 64 entries, and the bench models all of it. Both hashes of any key can be worked out by hand, and the complement hash lands in a slot whose contents the bench controls. Every miss can therefore be run through all sixteen reads, and entries can be made to collide across both slots. The bench varies the memory response latency to exercise the single-outstanding rule.

// File: rtl/hpt_walker_pkg.sv
package hpt_walker_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } walk_state_t;

  localparam int unsigned PTE_W         = 64;
  localparam int unsigned PTE_VALID_BIT = 63;
  localparam int unsigned PTE_KIND_BIT  = 62;
  localparam int unsigned PTE_TAG_LSB   = 32;
  localparam int unsigned PTE_PPN_LSB   = 0;
  localparam int unsigned PTE_BYTE_SH   = 3;

endpackage

// File: rtl/hpt_rst_sync.sv
module hpt_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_out = sync_q;

endmodule

// File: rtl/hpt_hash.sv
module hpt_hash #(
  parameter int unsigned VPN_W     = 20,
  parameter int unsigned PID_W     = 6,
  parameter int unsigned SLOT_BITS = 6
) (
  input  logic [VPN_W-1:0]     vpn,
  input  logic [PID_W-1:0]     pid,
  output logic [SLOT_BITS-1:0] slot_pri,
  output logic [SLOT_BITS-1:0] slot_sec
);

  logic [SLOT_BITS-1:0] pid_fold;

  generate
    if (PID_W >= SLOT_BITS) begin : g_pid_trunc
      assign pid_fold = pid[SLOT_BITS-1:0];
    end else begin : g_pid_ext
      assign pid_fold = {{(SLOT_BITS-PID_W){1'b0}}, pid};
    end
  endgenerate

  assign slot_pri = vpn[SLOT_BITS-1:0] ^ pid_fold;
  assign slot_sec = ~slot_pri;

endmodule

// File: rtl/hpt_addr_gen.sv
module hpt_addr_gen #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned SLOT_BITS = 6,
  parameter int unsigned ENTRIES   = 8
) (
  input  logic [ADDR_W-1:0]          base,
  input  logic [SLOT_BITS-1:0]       slot,
  input  logic [$clog2(ENTRIES)-1:0] idx,
  output logic [ADDR_W-1:0]          addr
);

  import hpt_walker_pkg::*;

  localparam int unsigned IDX_W = $clog2(ENTRIES);
  localparam int unsigned OFF_W = SLOT_BITS + IDX_W + PTE_BYTE_SH;

  logic [ADDR_W-1:0] offset;

  generate
    if (ADDR_W > OFF_W) begin : g_pad
      assign offset = {{(ADDR_W-OFF_W){1'b0}}, slot, idx, {PTE_BYTE_SH{1'b0}}};
    end else begin : g_fit
      assign offset = ADDR_W'({slot, idx, {PTE_BYTE_SH{1'b0}}});
    end
  endgenerate

  assign addr = base + offset;

endmodule

// File: rtl/hpt_entry_match.sv
module hpt_entry_match #(
  parameter int unsigned VPN_W = 20,
  parameter int unsigned PPN_W = 20
) (
  input  logic [63:0]      pte,
  input  logic [VPN_W-1:0] vpn,
  input  logic             kind,
  output logic             match,
  output logic [PPN_W-1:0] ppn
);

  import hpt_walker_pkg::*;

  logic tag_eq;

  assign tag_eq = (pte[PTE_TAG_LSB +: VPN_W] == vpn);
  assign match  = pte[PTE_VALID_BIT] && (pte[PTE_KIND_BIT] == kind) && tag_eq;
  assign ppn    = pte[PTE_PPN_LSB +: PPN_W];

endmodule

// File: rtl/hpt_walker.sv
module hpt_walker #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned VPN_W     = 20,
  parameter int unsigned PPN_W     = 20,
  parameter int unsigned PID_W     = 6,
  parameter int unsigned SLOT_BITS = 6,
  parameter int unsigned ENTRIES   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VPN_W-1:0]  req_vpn,
  input  logic [PID_W-1:0]  req_pid,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [63:0]       mem_rdata,
  output logic              done,
  output logic              hit,
  output logic [PPN_W-1:0]  ppn
);

  import hpt_walker_pkg::*;

  localparam int unsigned IDX_W = $clog2(ENTRIES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic rst_n_s;

  walk_state_t          state_q, state_d;
  logic [VPN_W-1:0]     vpn_q;
  logic [PID_W-1:0]     pid_q;
  logic [ADDR_W-1:0]    base_q;
  logic                 kind_q, kind_d;
  logic [IDX_W-1:0]     idx_q, idx_d;
  logic                 hit_q, hit_d;
  logic [PPN_W-1:0]     ppn_q, ppn_d;

  logic                 ctx_en, pos_en, res_en;
  logic [SLOT_BITS-1:0] slot_pri, slot_sec, slot_cur;
  logic                 ent_match;
  logic [PPN_W-1:0]     ent_ppn;
  logic                 last_entry;

  hpt_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  hpt_hash #(
    .VPN_W     (VPN_W),
    .PID_W     (PID_W),
    .SLOT_BITS (SLOT_BITS)
  ) u_hash (
    .vpn      (vpn_q),
    .pid      (pid_q),
    .slot_pri (slot_pri),
    .slot_sec (slot_sec)
  );

  assign slot_cur = kind_q ? slot_sec : slot_pri;

  hpt_addr_gen #(
    .ADDR_W    (ADDR_W),
    .SLOT_BITS (SLOT_BITS),
    .ENTRIES   (ENTRIES)
  ) u_addr (
    .base (base_q),
    .slot (slot_cur),
    .idx  (idx_q),
    .addr (mem_addr)
  );

  hpt_entry_match #(
    .VPN_W (VPN_W),
    .PPN_W (PPN_W)
  ) u_match (
    .pte   (mem_rdata),
    .vpn   (vpn_q),
    .kind  (kind_q),
    .match (ent_match),
    .ppn   (ent_ppn)
  );

  assign last_entry = (idx_q == LAST_IDX);

  // Next-state logic
  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    idx_d   = idx_q;
    hit_d   = hit_q;
    ppn_d   = ppn_q;
    ctx_en  = 1'b0;
    pos_en  = 1'b0;
    res_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          ctx_en  = 1'b1;
          pos_en  = 1'b1;
          kind_d  = 1'b0;
          idx_d   = '0;
          state_d = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (mem_rvalid) begin
          if (ent_match) begin
            res_en  = 1'b1;
            hit_d   = 1'b1;
            ppn_d   = ent_ppn;
            state_d = ST_RESP;
          end else if (!last_entry) begin
            pos_en  = 1'b1;
            idx_d   = idx_q + IDX_W'(1);
            state_d = ST_ISSUE;
          end else if (!kind_q) begin
            pos_en  = 1'b1;
            kind_d  = 1'b1;
            idx_d   = '0;
            state_d = ST_ISSUE;
          end else begin
            res_en  = 1'b1;
            hit_d   = 1'b0;
            ppn_d   = '0;
            state_d = ST_RESP;
          end
        end
      end
      ST_RESP: begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_IDLE;
      vpn_q   <= '0;
      pid_q   <= '0;
      base_q  <= '0;
      kind_q  <= 1'b0;
      idx_q   <= '0;
      hit_q   <= 1'b0;
      ppn_q   <= '0;
    end else begin
      state_q <= state_d;
      if (ctx_en) begin
        vpn_q  <= req_vpn;
        pid_q  <= req_pid;
        base_q <= tbl_base;
      end
      if (pos_en) begin
        kind_q <= kind_d;
        idx_q  <= idx_d;
      end
      if (res_en) begin
        hit_q <= hit_d;
        ppn_q <= ppn_d;
      end
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign mem_req   = (state_q == ST_ISSUE);
  assign done      = (state_q == ST_RESP);
  assign hit       = hit_q;
  assign ppn       = ppn_q;

endmodule

// File: rtl/hpt_walker_chk.sv
module hpt_walker_chk #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned PPN_W   = 20,
  parameter int unsigned ENTRIES = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rvalid,
  input logic              done,
  input logic              hit,
  input logic [PPN_W-1:0]  ppn
);

  localparam int unsigned CNT_W = $clog2(2 * ENTRIES) + 1;
  localparam logic [CNT_W-1:0] MAX_RD = CNT_W'(2 * ENTRIES);

  logic             pend_q;
  logic [CNT_W-1:0] rd_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      rd_cnt_q <= '0;
    end else begin
      if (mem_req) begin
        pend_q <= 1'b1;
      end else if (mem_rvalid) begin
        pend_q <= 1'b0;
      end
      if (req_valid && req_ready) begin
        rd_cnt_q <= '0;
      end else if (mem_req && (rd_cnt_q != {CNT_W{1'b1}})) begin
        rd_cnt_q <= rd_cnt_q + CNT_W'(1);
      end
    end
  end

  // R7: no new read while one is pending
  a_r7_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !pend_q);

  // R7: read request is a single-cycle pulse
  a_r7_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R2: entry reads are word aligned
  a_r2_addr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[2:0] == 3'b000));

  // R9: done lasts one cycle and the walker is idle next
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));

  // R8: idle excludes reads and results
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_req && !done));

  // R6: a miss follows every read of both slots and clears ppn
  a_r6_miss_full_scan: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !hit) |-> ((rd_cnt_q == MAX_RD) && (ppn == '0)));

  // R4: a hit follows at least one and at most all reads
  a_r4_hit_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (done && hit) |-> ((rd_cnt_q != '0) && (rd_cnt_q <= MAX_RD)));

endmodule

bind hpt_walker hpt_walker_chk #(
  .ADDR_W  (ADDR_W),
  .PPN_W   (PPN_W),
  .ENTRIES (ENTRIES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .mem_req    (mem_req),
  .mem_addr   (mem_addr),
  .mem_rvalid (mem_rvalid),
  .done       (done),
  .hit        (hit),
  .ppn        (ppn)
);

// File: tb/hpt_walker_tb.sv
`timescale 1ns/1ps
module hpt_walker_tb;

  localparam int unsigned ADDR_W    = 32;
  localparam int unsigned VPN_W     = 12;
  localparam int unsigned PPN_W     = 12;
  localparam int unsigned PID_W     = 3;
  localparam int unsigned SLOT_BITS = 3;
  localparam int unsigned ENTRIES   = 8;

  logic              clk;
  logic              rst_n;
  logic [ADDR_W-1:0] tbl_base;
  logic              req_valid;
  logic              req_ready;
  logic [VPN_W-1:0]  req_vpn;
  logic [PID_W-1:0]  req_pid;
  logic              mem_req;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_rvalid;
  logic [63:0]       mem_rdata;
  logic              done;
  logic              hit;
  logic [PPN_W-1:0]  ppn;

  hpt_walker #(
    .ADDR_W    (ADDR_W),
    .VPN_W     (VPN_W),
    .PPN_W     (PPN_W),
    .PID_W     (PID_W),
    .SLOT_BITS (SLOT_BITS),
    .ENTRIES   (ENTRIES)
  ) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .tbl_base   (tbl_base),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_vpn    (req_vpn),
    .req_pid    (req_pid),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .done       (done),
    .hit        (hit),
    .ppn        (ppn)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks;
  int fails;
  bit finished;

  logic [63:0] tbl [0:63];
  logic [31:0] mem_base;
  logic [31:0] rd_log [0:31];
  int rd_n;
  int bad_addr;
  int overlap;
  int lat;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input bit v, input bit k, input logic [11:0] tag, input logic [11:0] pp);
    logic [63:0] e;
    e = '0;
    e[63] = v;
    e[62] = k;
    e[43:32] = tag;
    e[11:0] = pp;
    return e;
  endfunction

  function automatic logic [2:0] h_pri(input logic [11:0] v, input logic [2:0] p);
    return v[2:0] ^ p;
  endfunction

  function automatic logic [31:0] ent_addr(input logic [31:0] b, input logic [2:0] s, input int k);
    return b + 32'(s) * 32'd64 + 32'(k) * 32'd8;
  endfunction

  task automatic clear_tbl();
    for (int i = 0; i < 64; i++) tbl[i] = '0;
  endtask

  // Memory responder
  initial begin
    mem_rvalid = 1'b0;
    mem_rdata  = '0;
    forever begin
      @(negedge clk);
      while (mem_req) begin
        logic [31:0] a;
        logic [31:0] off;
        a = mem_addr;
        if (rd_n < 32) rd_log[rd_n] = a;
        rd_n++;
        off = a - mem_base;
        repeat (lat) begin
          @(negedge clk);
          if (mem_req) overlap++;
        end
        if (off >= 32'd512 || a[2:0] != 3'b000) begin
          bad_addr++;
          mem_rdata = '0;
        end else begin
          mem_rdata = tbl[off[8:3]];
        end
        mem_rvalid = 1'b1;
        @(negedge clk);
        mem_rvalid = 1'b0;
      end
    end
  end

  task automatic do_walk(input logic [11:0] v, input logic [2:0] p,
                         output logic h, output logic [11:0] pp, output int nrd);
    int t;
    @(negedge clk);
    rd_n = 0;
    req_vpn = v;
    req_pid = p;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (!done && t < 500) begin
      @(negedge clk);
      t++;
    end
    check(t < 500, "R4 result timeout", 64'(t), 64'd500);
    h = hit;
    pp = ppn;
    nrd = rd_n;
    @(negedge clk);
    check(!done && req_ready, "R9 done one cycle then ready", {done, req_ready}, 2'b01);
  endtask

  task automatic t_reset();
    check(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 64'd1);
    check(done == 1'b0, "R1 done low after reset", 64'(done), 64'd0);
    check(mem_req == 1'b0, "R1 no read after reset", 64'(mem_req), 64'd0);
  endtask

  task automatic t_primary_first();
    logic h; logic [11:0] pp; int n;
    tbl[7*8+0] = mk(1, 0, 12'h0A5, 12'h5B3);
    do_walk(12'h0A5, 3'd2, h, pp, n);
    check(h == 1'b1, "R4 hit at primary entry 0", 64'(h), 64'd1);
    check(pp == 12'h5B3, "R4 ppn primary entry 0", 64'(pp), 64'h5B3);
    check(n == 1, "R4 one read", 64'(n), 64'd1);
    check(rd_log[0] == ent_addr(mem_base, h_pri(12'h0A5, 3'd2), 0), "R2 primary slot address",
          64'(rd_log[0]), 64'(ent_addr(mem_base, 3'd7, 0)));
  endtask

  task automatic fill_decoys();
    tbl[4*8+0] = mk(0, 0, 12'h2F0, 12'h001);
    tbl[4*8+1] = mk(1, 1, 12'h2F0, 12'h002);
    tbl[4*8+2] = mk(1, 0, 12'h2F1, 12'h003);
    tbl[4*8+3] = mk(1, 0, 12'h0F0, 12'h004);
    tbl[4*8+5] = mk(1, 0, 12'h2F0, 12'hABC);
    tbl[4*8+6] = mk(1, 0, 12'h2F0, 12'hDEF);
  endtask

  task automatic t_decoys(input string tag);
    logic h; logic [11:0] pp; int n; bit seq_ok;
    fill_decoys();
    do_walk(12'h2F0, 3'd4, h, pp, n);
    check(h == 1'b1 && pp == 12'hABC, {"R3 decoys skipped, R4 first match ", tag}, {h, pp}, {1'b1, 12'hABC});
    check(n == 6, {"R4 stop after first match ", tag}, 64'(n), 64'd6);
    seq_ok = 1'b1;
    for (int k = 0; k < 6; k++) if (rd_log[k] != ent_addr(mem_base, 3'd4, k)) seq_ok = 1'b0;
    check(seq_ok, {"R2 sequential entry addresses ", tag}, 64'(rd_log[5]), 64'(ent_addr(mem_base, 3'd4, 5)));
  endtask

  task automatic t_secondary();
    logic h; logic [11:0] pp; int n;
    tbl[2*8+4] = mk(1, 1, 12'h123, 12'h0EE);
    tbl[5*8+1] = mk(1, 0, 12'h123, 12'h0DD);
    tbl[5*8+3] = mk(1, 1, 12'h123, 12'h7E1);
    do_walk(12'h123, 3'd1, h, pp, n);
    check(h == 1'b1 && pp == 12'h7E1, "R5 hit in secondary slot, R3 kind bit", {h, pp}, {1'b1, 12'h7E1});
    check(n == 12, "R5 reads over both slots", 64'(n), 64'd12);
    check(rd_log[7] == ent_addr(mem_base, 3'd2, 7), "R5 primary scanned fully",
          64'(rd_log[7]), 64'(ent_addr(mem_base, 3'd2, 7)));
    check(rd_log[8] == ent_addr(mem_base, 3'd5, 0), "R5 secondary slot is complement",
          64'(rd_log[8]), 64'(ent_addr(mem_base, 3'd5, 0)));
  endtask

  task automatic t_miss();
    logic h; logic [11:0] pp; int n;
    tbl[0*8+2] = mk(1, 0, 12'h3C1, 12'h111);
    tbl[7*8+5] = mk(0, 1, 12'h3C0, 12'h222);
    do_walk(12'h3C0, 3'd0, h, pp, n);
    check(h == 1'b0, "R6 unresolved miss", 64'(h), 64'd0);
    check(pp == 12'h000, "R6 ppn zero on miss", 64'(pp), 64'd0);
    check(n == 16, "R6 all sixteen entries read", 64'(n), 64'd16);
  endtask

  task automatic t_busy_ignore();
    bit busy_ok; int t; int extra; logic h; logic [11:0] pp; int n;
    @(negedge clk);
    rd_n = 0;
    req_vpn = 12'h0A5;
    req_pid = 3'd2;
    req_valid = 1'b1;
    @(negedge clk);
    req_vpn = 12'h3C0;
    req_pid = 3'd0;
    busy_ok = 1'b1;
    t = 0;
    while (!done && t < 500) begin
      if (req_ready) busy_ok = 1'b0;
      @(negedge clk);
      t++;
    end
    req_valid = 1'b0;
    h = hit;
    pp = ppn;
    check(busy_ok, "R8 ready low while busy", 64'(busy_ok), 64'd1);
    check(h == 1'b1 && pp == 12'h5B3, "R8 result belongs to first request", {h, pp}, {1'b1, 12'h5B3});
    extra = 0;
    repeat (10) begin
      @(negedge clk);
      if (done) extra++;
    end
    n = rd_n;
    check(n == 1 && extra == 0, "R8 held request started nothing", {32'(n), 32'(extra)}, {32'd1, 32'd0});
  endtask

  task automatic t_base_latched();
    logic h; logic [11:0] pp; int n; int bad0; int t;
    bad0 = bad_addr;
    @(negedge clk);
    rd_n = 0;
    req_vpn = 12'h123;
    req_pid = 3'd1;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    tbl_base = 32'h0002_0000;
    t = 0;
    while (!done && t < 500) begin
      @(negedge clk);
      t++;
    end
    h = hit; pp = ppn; n = rd_n;
    tbl_base = mem_base;
    check(bad_addr == bad0, "R10 reads stay in latched table", 64'(bad_addr - bad0), 64'd0);
    check(h == 1'b1 && pp == 12'h7E1 && n == 12, "R10 result with moved base pin",
          {h, pp, 32'(n)}, {1'b1, 12'h7E1, 32'd12});
  endtask

  task automatic t_new_base();
    logic h; logic [11:0] pp; int n;
    mem_base = 32'h0000_8000;
    tbl_base = 32'h0000_8000;
    do_walk(12'h0A5, 3'd2, h, pp, n);
    check(rd_log[0] == 32'h0000_81C0, "R2 slot address on new base", 64'(rd_log[0]), 64'h81C0);
    check(h == 1'b1 && pp == 12'h5B3, "R2 hit on new base", {h, pp}, {1'b1, 12'h5B3});
  endtask

  initial begin
    checks = 0;
    fails = 0;
    finished = 1'b0;
    rd_n = 0;
    bad_addr = 0;
    overlap = 0;
    lat = 1;
    mem_base = 32'h0000_4000;
    tbl_base = 32'h0000_4000;
    req_valid = 1'b0;
    req_vpn = '0;
    req_pid = '0;
    clear_tbl();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    t_reset();
    t_primary_first();
    t_decoys("lat1");
    lat = 3;
    t_secondary();
    t_miss();
    lat = 2;
    t_busy_ignore();
    t_base_latched();
    lat = 4;
    t_decoys("lat4");
    lat = 1;
    t_new_base();
    check(overlap == 0, "R7 no read while one pending", 64'(overlap), 64'd0);
    check(bad_addr == 0, "R2 all reads inside table", 64'(bad_addr), 64'd0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R9 watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule